// File: doc/BRIEF.md
# Configurable Binary Correlator Array

The block correlates serial bit streams against a stored 256-bit pattern. It is built from eight sections of 32 taps each. Every tap holds one bit of a shifting data stream and compares it with its own reference bit. A per-tap enable can exclude the tap from the result. The tally of enabled taps that agree becomes the score. The score is added to an offset and to a 13-bit cascade word from an upstream device, which gives the correlation output.

A set-up word is latched only while reset is held. It decides, for each section below the top one, whether that section reads its own data input bit or the serial output of the section above it. It also decides whether the array acts as one long correlator or as two independent four-section correlators. In the split form, each half has its own offset, and the second half's result leaves on the auxiliary output. New reference and enable words are staged per section through a write port. They are copied into the working taps on any clock edge where the active-low transfer strobe is sampled low, and the data keeps shifting while this happens.

Top module: `bincorr_array`

## Requirements
- R1: A tap counts toward the score exactly when its enable bit is 1 and its data bit equals its reference bit. A tap whose enable bit is 0 never counts.
- R2: In single mode (`cfg_dual`=0), `cas_o` after clock edge N+2 equals, modulo 2^13, the sum of three terms: the count of matching enabled taps over the shift contents and working words present after edge N, `cfg_off_a`, and the `cas_in` value sampled at edge N+2. `aux_o` then carries no score.
- R3: Each section is a 32-stage shift register that takes in one new bit on every edge outside reset. Section 7 always takes `din[7]`. Section k<7 takes `din[k]` when `cfg_chain[k]`=0, and takes the last stage of section k+1 when `cfg_chain[k]`=1.
- R4: `dout[k]` is the last stage of the final section of the chain that starts at section k. Section k hands on to section k-1 while `cfg_chain[k-1]`=1. With every link set, a bit applied on `din[7]` appears on `dout[7]` 256 edges later.
- R5: Each section's partial tally is registered and lies in 0..32.
- R6: An edge at which `xfer_n` is sampled low copies every staged reference and enable word into the working taps. The change shows in `cas_o` exactly two edges later, and the data keeps shifting meanwhile.
- R7: A staged write (`pre_we`=1, section index `pre_stage`, words `pre_ref`/`pre_mask`, bit j belonging to tap j) has no effect on the score until a transfer. While `xfer_n` stays high, the working words hold.
- R8: The set-up word (`cfg_chain`, `cfg_dual`, `cfg_off_a`, `cfg_off_b`) is captured on a reset edge where `cfg_we`=1. A reset edge where `cfg_we`=0 restores all-zero set-up. A `cfg_we` pulse outside reset changes nothing.
- R9: In dual mode, section 3 never links to section 4. `cas_o` carries zeros in bits 12..9 and, in bits 8..0, the low nine bits of (tally of sections 7..4 + `cfg_off_a` + `cas_in`). `aux_o` carries the low nine bits of (tally of sections 3..0 + `cfg_off_b`). Both have the same latency as in R2.
- R10: In single mode, `aux_o[7:0]` carries the working reference bit of tap 31 from the same section that `dout` selects for each bit, and `aux_o[8]` is 0.
- R11: While `rst` is high, at every edge all shift, staged, working and score registers clear. `cas_o`, `dout` and `aux_o` then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Per-section serial data input bits |
| pre_we | input | 1 | Staged write enable |
| pre_stage | input | 3 | Section index for the staged write |
| pre_ref | input | 32 | Staged reference word |
| pre_mask | input | 32 | Staged tap enable word |
| xfer_n | input | 1 | Transfer strobe, active low |
| cfg_we | input | 1 | Set-up write, honoured only during reset |
| cfg_chain | input | 7 | Link select for sections 6..0 |
| cfg_dual | input | 1 | 1 = two independent correlators |
| cfg_off_a | input | 13 | Offset for the single or upper correlator |
| cfg_off_b | input | 9 | Offset for the lower correlator in dual mode |
| cas_in | input | 13 | Cascade input word |
| dout | output | 8 | Delayed data, routed per chain |
| aux_o | output | 9 | Routed reference bits, or lower score in dual mode |
| cas_o | output | 13 | Correlation result |

## Verification
The hardest case to reach is a transfer that lands while the data is still moving. The test has to show that the score switches to the new words on exactly the second edge after the strobe. It must not switch one edge early or late. Staged words that were never transferred must not affect it. A directed task parks a fully enabled all-match pattern and stages a change for one section only. It pulses the strobe for a single edge and then samples three consecutive cycles. Longer random runs mix strobes, staged writes, random links and both modes against a cycle-level model of the array.

// File: rtl/bincorr_pkg.sv
package bincorr_pkg;
  localparam int NSTG = 8;
  localparam int TAPS = 32;
  localparam int CW   = 13;
  localparam int DW   = 9;

  typedef struct packed {
    logic [NSTG-2:0] chain;
    logic            dual;
    logic [CW-1:0]   off_a;
    logic [DW-1:0]   off_b;
  } cfg_t;

  // link pattern after the split rule: section NSTG/2-1 is cut off in dual mode
  function automatic logic [NSTG-2:0] f_links(input cfg_t c);
    logic [NSTG-2:0] l;
    l = c.chain;
    if (c.dual) l[NSTG/2-1] = 1'b0;
    return l;
  endfunction

  // for each section, pick the signal of the last section of the chain starting there
  function automatic logic [NSTG-1:0] f_route(input logic [NSTG-1:0] v,
                                               input logic [NSTG-2:0] l);
    logic [NSTG-1:0] r;
    r[0] = v[0];
    for (int i = 1; i < NSTG; i++) r[i] = l[i-1] ? r[i-1] : v[i];
    return r;
  endfunction
endpackage

// File: rtl/bincorr_stage.sv
module bincorr_stage #(
  parameter int TAPS = 32,
  localparam int CNTW = $clog2(TAPS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sin,
  input  logic            pre_we,
  input  logic [TAPS-1:0] pre_ref,
  input  logic [TAPS-1:0] pre_mask,
  input  logic            xfer_n,
  output logic            sout,
  output logic            ref_msb,
  output logic [CNTW-1:0] cnt_o
);
  logic [TAPS-1:0] sr, pre_r, pre_m, wk_r, wk_m;
  logic [TAPS-1:0] hit_vec;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [CNTW-1:0] f_tally(input logic [TAPS-1:0] h);
    logic [CNTW-1:0] c;
    c = '0;
    for (int j = 0; j < TAPS; j++) c += CNTW'(h[j]);
    return c;
  endfunction

  assign hit_vec = ~(sr ^ wk_r) & wk_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; pre_r <= '0; pre_m <= '0; wk_r <= '0; wk_m <= '0; cnt_q <= '0;
    end else begin
      sr    <= {sr[TAPS-2:0], sin};
      cnt_q <= f_tally(hit_vec);
      if (pre_we) begin
        pre_r <= pre_ref;
        pre_m <= pre_mask;
      end
      if (!xfer_n) begin
        wk_r <= pre_r;
        wk_m <= pre_m;
      end
    end
  end

  assign sout    = sr[TAPS-1];
  assign ref_msb = wk_r[TAPS-1];
  assign cnt_o   = cnt_q;

  p_shift_in_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sr[0] == $past(sin));
  p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNTW'(TAPS));
  p_swap_load_r6: assert property (@(posedge clk) disable iff (rst)
    !xfer_n |=> (wk_r == $past(pre_r)) && (wk_m == $past(pre_m)));
  p_work_hold_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_n |=> $stable(wk_r) && $stable(wk_m));
endmodule

// File: rtl/bincorr_sum.sv
module bincorr_sum #(
  parameter int NSTG = 8,
  parameter int CNTW = 6,
  parameter int CW   = 13,
  parameter int DW   = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSTG*CNTW-1:0] cnt_flat,
  input  logic                 dual,
  input  logic [CW-1:0]        off_a,
  input  logic [DW-1:0]        off_b,
  input  logic [CW-1:0]        cas_in,
  output logic [CW-1:0]        cas_o,
  output logic [DW-1:0]        aux_score
);
  localparam int HALF = NSTG / 2;
  logic [CW-1:0] cas_q;
  logic [DW-1:0] aux_q;

  function automatic logic [CW-1:0] f_add(input logic [NSTG*CNTW-1:0] v,
                                          input int lo, input int hi);
    logic [CW-1:0] a;
    a = '0;
    for (int s = lo; s <= hi; s++) a += CW'(v[s*CNTW +: CNTW]);
    return a;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_q <= '0;
      aux_q <= '0;
    end else if (dual) begin
      cas_q <= CW'(DW'(f_add(cnt_flat, HALF, NSTG-1) + off_a + cas_in));
      aux_q <= DW'(f_add(cnt_flat, 0, HALF-1) + CW'(off_b));
    end else begin
      cas_q <= f_add(cnt_flat, 0, NSTG-1) + off_a + cas_in;
      aux_q <= '0;
    end
  end

  assign cas_o     = cas_q;
  assign aux_score = aux_q;

  p_dual_upper_r9: assert property (@(posedge clk) disable iff (rst)
    dual |=> cas_o[CW-1:DW] == '0);
endmodule

// File: rtl/bincorr_array.sv
module bincorr_array
  import bincorr_pkg::*;
#(
  localparam int SW   = $clog2(NSTG),
  localparam int CNTW = $clog2(TAPS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSTG-1:0] din,
  input  logic            pre_we,
  input  logic [SW-1:0]   pre_stage,
  input  logic [TAPS-1:0] pre_ref,
  input  logic [TAPS-1:0] pre_mask,
  input  logic            xfer_n,
  input  logic            cfg_we,
  input  logic [NSTG-2:0] cfg_chain,
  input  logic            cfg_dual,
  input  logic [CW-1:0]   cfg_off_a,
  input  logic [DW-1:0]   cfg_off_b,
  input  logic [CW-1:0]   cas_in,
  output logic [NSTG-1:0] dout,
  output logic [DW-1:0]   aux_o,
  output logic [CW-1:0]   cas_o
);
  cfg_t                 cfg_q;
  logic [NSTG-2:0]      links;
  logic [NSTG-1:0]      stg_in, stg_out, stg_ref;
  logic [NSTG*CNTW-1:0] cnt_flat;
  logic [DW-1:0]        aux_score;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (cfg_we) cfg_q <= '{chain: cfg_chain, dual: cfg_dual, off_a: cfg_off_a, off_b: cfg_off_b};
      else        cfg_q <= '0;
    end
  end

  assign links = f_links(cfg_q);

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    logic [CNTW-1:0] c;
    if (s == NSTG-1) begin : g_head
      assign stg_in[s] = din[s];
    end else begin : g_link
      assign stg_in[s] = links[s] ? stg_out[s+1] : din[s];
    end
    bincorr_stage #(.TAPS(TAPS)) u_stage (
      .clk(clk), .rst(rst), .sin(stg_in[s]),
      .pre_we(pre_we && (pre_stage == SW'(s))),
      .pre_ref(pre_ref), .pre_mask(pre_mask), .xfer_n(xfer_n),
      .sout(stg_out[s]), .ref_msb(stg_ref[s]), .cnt_o(c)
    );
    assign cnt_flat[s*CNTW +: CNTW] = c;
  end

  bincorr_sum #(.NSTG(NSTG), .CNTW(CNTW), .CW(CW), .DW(DW)) u_sum (
    .clk(clk), .rst(rst), .cnt_flat(cnt_flat), .dual(cfg_q.dual),
    .off_a(cfg_q.off_a), .off_b(cfg_q.off_b), .cas_in(cas_in),
    .cas_o(cas_o), .aux_score(aux_score)
  );

  assign dout  = f_route(stg_out, links);
  assign aux_o = cfg_q.dual ? aux_score : DW'(f_route(stg_ref, links));

  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg_q));
  p_split_cut_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_q.dual |-> (stg_in[NSTG/2-1] == din[NSTG/2-1]));
endmodule

// File: tb/bincorr_array_bench.sv
module bincorr_array_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  din = '0;
  logic        pre_we = 1'b0;
  logic [2:0]  pre_stage = '0;
  logic [31:0] pre_ref = '0, pre_mask = '0;
  logic        xfer_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_chain = '0;
  logic        cfg_dual = 1'b0;
  logic [12:0] cfg_off_a = '0, cas_in = '0;
  logic [8:0]  cfg_off_b = '0;
  logic [7:0]  dout;
  logic [8:0]  aux_o;
  logic [12:0] cas_o;

  bincorr_array u_bincorr_array (.*);

  always #4 clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit chk_on = 1'b0, done = 1'b0;
  string cur_tag = "R2";

  // reference model state
  logic [31:0] m_sr[8], m_pr[8], m_pm[8], m_wr[8], m_wm[8];
  int          m_cnt[8];
  logic [12:0] m_cas;
  logic [8:0]  m_aux;
  logic [6:0]  m_chain;
  logic        m_dual;
  logic [12:0] m_oa;
  logic [8:0]  m_ob;

  function automatic bit lk(input int k);
    return m_chain[k] && !(m_dual && k == 3);
  endfunction

  function automatic int last_of(input int i);
    int t = i;
    while (t > 0 && lk(t-1)) t--;
    return t;
  endfunction

  always @(posedge clk) begin
    logic [7:0] sin;
    int a, b;
    if (rst) begin
      for (int s = 0; s < 8; s++) begin
        m_sr[s] <= '0; m_pr[s] <= '0; m_pm[s] <= '0; m_wr[s] <= '0; m_wm[s] <= '0; m_cnt[s] <= 0;
      end
      m_cas <= '0; m_aux <= '0;
      m_chain <= cfg_we ? cfg_chain : '0;
      m_dual  <= cfg_we ? cfg_dual  : 1'b0;
      m_oa    <= cfg_we ? cfg_off_a : '0;
      m_ob    <= cfg_we ? cfg_off_b : '0;
    end else begin
      a = m_cnt[7] + m_cnt[6] + m_cnt[5] + m_cnt[4];
      b = m_cnt[3] + m_cnt[2] + m_cnt[1] + m_cnt[0];
      if (m_dual) begin
        m_cas <= 13'((a + m_oa + cas_in) % 512);
        m_aux <= 9'((b + m_ob) % 512);
      end else begin
        m_cas <= 13'((a + b + m_oa + cas_in) % 8192);
        m_aux <= '0;
      end
      for (int s = 0; s < 8; s++) begin
        m_cnt[s] <= $countones(~(m_sr[s] ^ m_wr[s]) & m_wm[s]);
        sin[s] = (s < 7 && lk(s)) ? m_sr[s+1][31] : din[s];
        m_sr[s] <= {m_sr[s][30:0], sin[s]};
        if (!xfer_n) begin m_wr[s] <= m_pr[s]; m_wm[s] <= m_pm[s]; end
      end
      if (pre_we) begin m_pr[pre_stage] <= pre_ref; m_pm[pre_stage] <= pre_mask; end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      logic [7:0] ed, er;
      for (int i = 0; i < 8; i++) begin
        ed[i] = m_sr[last_of(i)][31];
        er[i] = m_wr[last_of(i)][31];
      end
      chk(cas_o == m_cas, m_dual ? "R9" : cur_tag, cas_o, m_cas);
      chk(dout == ed, "R4", dout, ed);
      if (m_dual) chk(aux_o == m_aux, "R9", aux_o, m_aux);
      else        chk(aux_o == {1'b0, er}, "R10", aux_o, {1'b0, er});
    end
  end

  task automatic t_configure(input logic [6:0] ch, input logic du,
                             input logic [12:0] oa, input logic [8:0] ob);
    @(negedge clk);
    chk_on = 1'b0; rst = 1'b1; cfg_we = 1'b0; xfer_n = 1'b1; pre_we = 1'b0; din = '0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_chain = ch; cfg_dual = du; cfg_off_a = oa; cfg_off_b = ob;
    @(negedge clk);
    rst = 1'b0; cfg_we = 1'b0;
    chk_on = 1'b1;
  endtask

  task automatic t_stage(input int s, input logic [31:0] r, input logic [31:0] m);
    @(negedge clk);
    pre_we = 1'b1; pre_stage = 3'(s); pre_ref = r; pre_mask = m;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic t_xfer();
    @(negedge clk); xfer_n = 1'b0;
    @(negedge clk); xfer_n = 1'b1;
  endtask

  task automatic t_idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();   // R11
    @(negedge clk); rst = 1'b1; chk_on = 1'b0; din = 8'hff; cas_in = 13'h1abc;
    t_idle(3);
    chk(cas_o == 0, "R11", cas_o, 0);
    chk(dout == 0, "R11", dout, 0);
    chk(aux_o == 0, "R11", aux_o, 0);
    din = '0; cas_in = '0;
  endtask

  task automatic t_match_and_mask();   // R1 R5
    cur_tag = "R1";
    t_configure(7'h00, 1'b0, 13'd5, 9'd0);
    cas_in = 13'd3;
    for (int s = 0; s < 8; s++) t_stage(s, 32'h0, 32'hffff_ffff);
    t_xfer();
    t_idle(40);
    chk(cas_o == 13'd264, "R1", cas_o, 264);
    for (int s = 0; s < 8; s++) t_stage(s, 32'h0, 32'h0);
    t_xfer();
    t_idle(4);
    chk(cas_o == 13'd8, "R1", cas_o, 8);
    // single section partly matching: stage 5 enable low half, ref 0, data 0
    t_stage(5, 32'h0, 32'h0000_ffff);
    t_xfer();
    t_idle(4);
    chk(cas_o == 13'd24, "R5", cas_o, 24);
  endtask

  task automatic t_swap_exact();   // R6 R7
    cur_tag = "R6";
    t_stage(2, 32'h0, 32'hffff_ffff);   // staged only
    t_idle(5);
    chk(cas_o == 13'd24, "R7", cas_o, 24);
    @(negedge clk); xfer_n = 1'b0;
    @(negedge clk); xfer_n = 1'b1;
    chk(cas_o == 13'd24, "R6", cas_o, 24);
    @(negedge clk);
    chk(cas_o == 13'd24, "R6", cas_o, 24);
    @(negedge clk);
    chk(cas_o == 13'd56, "R6", cas_o, 56);
    cas_in = '0;
  endtask

  task automatic t_chain256();   // R3 R4
    int k;
    cur_tag = "R3";
    t_configure(7'h7f, 1'b0, 13'd0, 9'd0);
    @(negedge clk); din = 8'h80;
    @(negedge clk); din = 8'h00;
    k = 1;
    while (dout[7] !== 1'b1 && k < 400) begin @(negedge clk); k++; end
    chk(k == 256, "R4", k, 256);
    @(negedge clk);
    chk(dout[7] == 1'b0, "R3", dout[7], 0);
  endtask

  task automatic t_random(input bit du, input int n, input string tag);
    cur_tag = tag;
    t_configure(7'($urandom), du, 13'($urandom), 9'($urandom));
    for (int s = 0; s < 8; s++) t_stage(s, $urandom, $urandom);
    t_xfer();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = 8'($urandom); cas_in = 13'($urandom);
      pre_we = ($urandom % 4) == 0; pre_stage = 3'($urandom);
      pre_ref = $urandom; pre_mask = $urandom;
      xfer_n = ($urandom % 16) != 0;
    end
    @(negedge clk); pre_we = 1'b0; xfer_n = 1'b1;
  endtask

  task automatic t_cfg_ignored();   // R8
    t_random(1'b0, 50, "R8");
    @(negedge clk); cfg_we = 1'b1; cfg_chain = 7'h55; cfg_dual = ~m_dual; cfg_off_a = 13'h777;
    @(negedge clk); cfg_we = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); din = 8'($urandom); cas_in = 13'($urandom);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_idle(3);
    t_reset_state();
    t_match_and_mask();
    t_swap_exact();
    t_chain256();
    t_random(1'b0, 400, "R2");
    t_random(1'b1, 400, "R9");
    t_random(1'b0, 300, "R3");
    t_cfg_ignored();
    chk_on = 1'b0;
    t_idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule